// File: doc/BRIEF.md
# Distributed Randomized Crosspoint Scheduler

This block holds the schedule of an N-by-N crosspoint-buffered switch: one bit per crosspoint saying whether the input row may currently move a cell into that crosspoint's buffer. The set of active bits is always a partial matching, with no two in the same row and no two in the same column. Queue storage and cell movement stay in the fabric. The block only decides which crosspoints are enabled.

On every slot strobe, a 16-bit pseudo-random register that every port starts from the same seed names one candidate crosspoint. Only that crosspoint's bit may change in that slot.

The new value of the bit depends on three things: a random draw weighed against the candidate's queue length, whether the rest of its row and column is free, and the one-bit full or empty state its crosspoint buffer had at the previous slot. No request or grant messages are exchanged. The buffer occupancy bit is the only information passed between the input side and the output side.

Top module: `xpt_sched`

## Requirements
- R1: After reset, `sched` is all zeros, the random register holds `SEED`, and every crosspoint buffer is taken as empty.
- R2: The random register L advances only on a cycle with `slot` high. Its next value is `(L>>1) ^ (L[0] ? 16'hB400 : 0)`. The candidate index is `L[7:0] mod N*N` and the draw is `L[15:8]`, both taken from L before it advances. Crosspoint k = i*N+j is input row i and output column j.
- R3: Without `slot` no schedule bit changes. With `slot`, every crosspoint other than the candidate keeps its bit.
- R4: An active candidate stays active when the draw is below its threshold and is cleared otherwise.
- R5: An inactive candidate becomes active only when the draw is below its threshold, no other crosspoint in its row or column is active, and its recorded buffer state is empty. Otherwise it stays inactive.
- R6: The threshold is the queue length `voq_len[k*QW +: QW]` saturated to 255. A queue length of 0 therefore never activates a crosspoint and never keeps one active.
- R7: Bit k of `xb_full` (1 = full) is recorded on each slot and used by the next slot's decision.
- R8: At every cycle, `sched` has at most one active bit per row and at most one per column.
- R9: The schedule register updates on the clock edge at which `slot` is high and is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | input | 1 | Slot strobe; one scheduling update per high cycle |
| voq_len | input | N*N*QW | Queue lengths, crosspoint k in bits k*QW +: QW |
| xb_full | input | N*N | Crosspoint buffer occupancy, 1 = full |
| sched | output | N*N | Schedule vector, bit k enables crosspoint k |

## Verification
The bench first drives long runs with every queue empty. A design that ignored the zero-length rule would switch crosspoints on during these runs. It then drives runs with maximum-length queues and a mix of full and empty buffers. A design that read the current buffer bit instead of the recorded one, or that forgot the column check, would activate crosspoints the model keeps off and would break the matching. Idle gaps between slots catch a random register or schedule that moves without the strobe. Random queue lengths and buffer patterns then exercise the threshold comparison near its edges.

// File: rtl/xpt_sched.sv
module xpt_sched #(
  parameter int N = 4,
  parameter int QW = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic [N*N*QW-1:0] voq_len,
  input  logic [N*N-1:0]    xb_full,
  output logic [N*N-1:0]    sched
);
  localparam int NX = N * N;
  localparam int CW = (NX > 1) ? $clog2(NX) : 1;

  logic [15:0]   lfsr;
  logic [NX-1:0] cb_prev;
  logic [CW-1:0] cand;
  logic [QW-1:0] len_c;
  logic [7:0]    thr;
  logic          busy, grant, nbit;

  wire [15:0] lfsr_nx = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);

  assign cand  = CW'({24'd0, lfsr[7:0]} % NX);
  assign len_c = voq_len[cand*QW +: QW];

  generate
    if (QW > 8) begin : g_sat
      assign thr = (|len_c[QW-1:8]) ? 8'hFF : len_c[7:0];
    end else begin : g_ext
      assign thr = 8'(len_c);
    end
  endgenerate

  assign grant = lfsr[15:8] < thr;

  always_comb begin
    int r, c;
    r = int'(cand) / N;
    c = int'(cand) % N;
    busy = 1'b0;
    for (int j = 0; j < N; j++)
      if (j != c && sched[r*N+j]) busy = 1'b1;
    for (int i = 0; i < N; i++)
      if (i != r && sched[i*N+c]) busy = 1'b1;
  end

  assign nbit = sched[cand] ? grant : (grant && !busy && !cb_prev[cand]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr    <= SEED;
      sched   <= '0;
      cb_prev <= '0;
    end else if (slot) begin
      lfsr        <= lfsr_nx;
      sched[cand] <= nbit;
      cb_prev     <= xb_full;
    end
  end
endmodule

// File: rtl/xpt_sched_chk.sv
module xpt_sched_chk #(
  parameter int N = 4,
  parameter int QW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slot,
  input logic [N*N-1:0]       sched,
  input logic [(N*N>1?$clog2(N*N):1)-1:0] cand,
  input logic [QW-1:0]        len_c,
  input logic [N*N-1:0]       cb_prev
);
  logic match_ok;
  always_comb begin
    match_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int j = 0; j < N; j++) begin
        rc += int'(sched[i*N+j]);
        cc += int'(sched[j*N+i]);
      end
      if (rc > 1 || cc > 1) match_ok = 1'b0;
    end
  end

  assert_matching_R8: assert property (@(posedge clk) disable iff (!rst_n) match_ok);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> $stable(sched));

  assert_one_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> $countones(sched ^ $past(sched)) <= 1);

  assert_zero_len_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && len_c == '0) |=> !sched[$past(cand)]);

  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !sched[cand] && cb_prev[cand]) |=> !sched[$past(cand)]);
endmodule

bind xpt_sched xpt_sched_chk #(.N(N), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .sched(sched),
  .cand(cand), .len_c(len_c), .cb_prev(cb_prev)
);

// File: tb/test_xpt_sched.sv
module test_xpt_sched;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int QW = 8;
  localparam int NX = N * N;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 0, rst_n = 0, slot = 0;
  logic [NX*QW-1:0] voq_len = '0;
  logic [NX-1:0] xb_full = '0;
  logic [NX-1:0] sched;

  xpt_sched #(.N(N), .QW(QW), .SEED(SEED)) i_xpt_sched (
    .clk(clk), .rst_n(rst_n), .slot(slot), .voq_len(voq_len),
    .xb_full(xb_full), .sched(sched));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0]   m_lfsr = SEED;
  logic [NX-1:0] m_sched = '0, m_cb = '0;
  logic [NX-1:0] exp_q[$];
  string         tag_q[$];

  task automatic chk(string tag, logic [NX-1:0] act, logic [NX-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sched=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) chk(tag_q.pop_front(), sched, exp_q.pop_front());
  end

  // model of R2, R4, R5, R6, R7
  task automatic model_slot();
    int k, r, c;
    logic [7:0] thr, draw;
    logic busy, g;
    k = int'(m_lfsr[7:0]) % NX;
    r = k / N; c = k % N;
    draw = m_lfsr[15:8];
    thr = 8'(voq_len[k*QW +: QW]);
    g = draw < thr;
    busy = 0;
    for (int j = 0; j < N; j++) if (j != c && m_sched[r*N+j]) busy = 1;
    for (int i = 0; i < N; i++) if (i != r && m_sched[i*N+c]) busy = 1;
    if (m_sched[k]) m_sched[k] = g;
    else m_sched[k] = g && !busy && !m_cb[k];
    m_cb = xb_full;
    m_lfsr = {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
  endtask

  task automatic drive(bit do_slot, string tag);
    @(negedge clk);
    slot = do_slot;
    if (do_slot) model_slot();
    @(posedge clk);
    #1;
    slot = 0;
    exp_q.push_back(m_sched);
    tag_q.push_back(tag);
  endtask

  task automatic set_all_len(int v);
    for (int k = 0; k < NX; k++) voq_len[k*QW +: QW] = QW'(v);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset empty", sched, '0);

    // R6: empty queues never activate
    set_all_len(0);
    for (int n = 0; n < 30; n++) drive(1, "R6 zero length");

    // R5/R7: max queues, all buffers full -> recorded full blocks activation
    set_all_len(255);
    xb_full = '1;
    for (int n = 0; n < 20; n++) drive(1, "R5 R7 full buffers");

    // R4/R5/R8: max queues, empty buffers, idle gaps for R3/R9
    xb_full = '0;
    for (int n = 0; n < 80; n++) begin
      drive(1, "R4 R5 R8 max length");
      if (n % 5 == 0) drive(0, "R3 idle hold");
    end

    // R2/R4/R6/R7: random lengths and buffer patterns
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NX; k++) voq_len[k*QW +: QW] = QW'($urandom_range(0, 255));
      xb_full = NX'($urandom);
      drive(1, "R2 R4 R6 R7 random");
      if (n % 7 == 0) drive(0, "R3 idle hold random");
    end

    // R4: queues drained -> active crosspoints clear once drawn
    set_all_len(0);
    for (int n = 0; n < 60; n++) drive(1, "R4 R6 drain");

    @(negedge clk);
    @(negedge clk);
    chk("R4 drained final", sched, m_sched);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule